// File: doc/BRIEF.md
# FIFO-Decoupled Two-Stage Speculative Pipeline

This block is a minimal two-stage processor core. A fetch stage reads instruction words from an internal instruction array and pushes them into a small instruction queue. An execute stage pops them from the queue head and applies them to an internal register file. Fetch always guesses that the next instruction is at the following address. When a branch-if-zero is taken at the head of the queue, the program counter is redirected and every speculatively fetched word is discarded in the same cycle.

Fetch and execute are guarded only by the queue state: fetch waits for "not full" and execute waits for "not empty". As a result both stages fire in the same cycle in steady state. A halt opcode at the queue head freezes the execute stage and raises a sticky `done` flag. While `run` is low, a simple load port fills the instruction array and the register file, and a peek port reads the registers back.

Top module: `fifo_pipe`

## Requirements
- R1: After reset `pcOut` is 0, `fifoLevel` is 0 and `done` is 0.
- R2: In a cycle with `run` high and the queue not full, fetch pushes the word at `pcOut` and increments `pcOut` by one (8-bit wrap). With `run` low, `pcOut` and `fifoLevel` do not change.
- R3: `fifoLevel` never exceeds FIFO_DEPTH (default 2). While the queue is full, fetch stalls and `pcOut` holds unless a taken branch redirects it.
- R4: Instruction word is 16 bits with the opcode in bits 15:14 (00 add). For add, bits 13:10 give the destination, 9:6 the first source and 5:2 the second source. It writes the 16-bit wrapped sum of the two source registers to the destination and pops the queue.
- R5: Opcode 01 is branch-if-zero, with the tested register in bits 13:10 and an absolute 8-bit target in bits 7:0. When the tested register is nonzero it only pops the queue; no register and no redirect change.
- R6: When the tested register is zero, the next `pcOut` equals the target and `fifoLevel` becomes 0 in the same cycle. A word fetched in that cycle is discarded, so wrong-path instructions never execute.
- R7: Fetch and execute both complete in the same cycle. A straight run of k adds followed by a halt raises `done` exactly k+2 cycles after `run` goes high.
- R8: Opcode 10 or 11 at the queue head stops execution, and `done` rises the next cycle. `done` then stays high until reset, and nothing more executes.
- R9: With `run` low, `ldImemEn` writes `ldData` to instruction address `ldAddr`, and `ldRegEn` writes `ldData` to register `ldAddr[3:0]`. `peekData` shows register `peekReg` combinationally.
- R10: For any program, the final register contents equal those of a strictly sequential, one-instruction-at-a-time interpretation of the same program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables fetch and execute |
| ldImemEn | input | 1 | Write strobe into the instruction array |
| ldRegEn | input | 1 | Write strobe into the register file |
| ldAddr | input | 8 | Load address (register index in bits 3:0) |
| ldData | input | 16 | Load data |
| peekReg | input | 4 | Register index to observe |
| peekData | output | 16 | Contents of register `peekReg` |
| pcOut | output | 8 | Current program counter |
| fifoLevel | output | clog2(FIFO_DEPTH+1) | Number of queued instructions |
| done | output | 1 | Sticky halt indication |

## Verification
The bench aims at the cycle where a taken branch meets a same-cycle fetch. A design that let the fetch win would leave a wrong-path word queued, and that word would corrupt a register. It fills the queue behind a halt to catch a design that overruns the depth or keeps advancing the program counter while full. It times straight-line code to expose a design that fetches and executes in alternate cycles, which would show up as late completion. Random programs with forward branches are compared against a sequential interpreter. This exposes wrong field decoding, lost dependencies between back-to-back adds, and not-taken branches that disturb state.

// File: rtl/fifo_pipe_pkg.sv
package fifo_pipe_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 16;
  localparam int REG_AW  = 4;
  localparam int REG_N   = 1 << REG_AW;
  localparam int IMEM_AW = 8;
  localparam int IMEM_N  = 1 << IMEM_AW;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_BZ   = 2'b01,
    OP_HALT = 2'b10,
    OP_STOP = 2'b11
  } opcode_e;

  typedef struct packed {
    logic fetch;
    logic dequeue;
    logic regWrite;
    logic branchTaken;
  } pipe_strobe_t;
endpackage

// File: rtl/fifo_pipe_ctrl.sv
module fifo_pipe_ctrl
  import fifo_pipe_pkg::*;
#(
  parameter int FIFO_DEPTH = 2,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [1:0]       headOp,
  input  logic             headZero,
  output pipe_strobe_t     strb,
  output logic             done
);
  logic queueFull, headValid, stopAtHead, execGo;

  assign queueFull  = (fifoLevel == LVL_W'(FIFO_DEPTH));
  assign headValid  = (fifoLevel != '0);
  assign stopAtHead = run && headValid && headOp[1];
  assign execGo     = run && headValid && !done && !headOp[1];

  always_comb begin
    strb             = '0;
    strb.fetch       = run && !queueFull;
    strb.dequeue     = execGo;
    strb.regWrite    = execGo && (headOp == OP_ADD);
    strb.branchTaken = execGo && (headOp == OP_BZ) && headZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           done <= 1'b0;
    else if (stopAtHead) done <= 1'b1;
  end
endmodule

// File: rtl/fifo_pipe_dp.sv
module fifo_pipe_dp
  import fifo_pipe_pkg::*;
#(
  parameter int FIFO_DEPTH = 2,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  pipe_strobe_t       strb,
  input  logic               ldImemEn,
  input  logic               ldRegEn,
  input  logic [IMEM_AW-1:0] ldAddr,
  input  logic [INSTR_W-1:0] ldData,
  input  logic [REG_AW-1:0]  peekReg,
  output logic [DATA_W-1:0]  peekData,
  output logic [IMEM_AW-1:0] pcOut,
  output logic [LVL_W-1:0]   fifoLevel,
  output logic [INSTR_W-1:0] headInstr,
  output logic               headZero
);
  logic [INSTR_W-1:0] imem    [IMEM_N];
  logic [DATA_W-1:0]  regFile [REG_N];
  logic [INSTR_W-1:0] fifoMem [FIFO_DEPTH];

  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [IMEM_AW-1:0] pc;
  logic [LVL_W-1:0]   level;
  logic [REG_AW-1:0]  dstSel, srcA, srcB;
  logic [DATA_W-1:0]  sum;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headInstr = fifoMem[rdPtr];
  assign dstSel    = headInstr[13:10];
  assign srcA      = headInstr[9:6];
  assign srcB      = headInstr[5:2];
  assign sum       = regFile[srcA] + regFile[srcB];
  assign headZero  = (regFile[dstSel] == '0);
  assign peekData  = regFile[peekReg];
  assign pcOut     = pc;
  assign fifoLevel = level;

  always_ff @(posedge clk) begin
    if (ldImemEn) imem[ldAddr] <= ldData;
  end

  always_ff @(posedge clk) begin
    if (ldRegEn)            regFile[ldAddr[REG_AW-1:0]] <= ldData;
    else if (strb.regWrite) regFile[dstSel] <= sum;
  end

  always_ff @(posedge clk) begin
    if (strb.fetch && !strb.branchTaken) fifoMem[wrPtr] <= imem[pc];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (strb.branchTaken) begin
      pc    <= headInstr[7:0];
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (strb.fetch) begin
        pc    <= pc + 1'b1;
        wrPtr <= bump(wrPtr);
      end
      if (strb.dequeue) rdPtr <= bump(rdPtr);
      level <= level + LVL_W'(strb.fetch) - LVL_W'(strb.dequeue);
    end
  end
endmodule

// File: rtl/fifo_pipe.sv
module fifo_pipe
  import fifo_pipe_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               run,
  input  logic                               ldImemEn,
  input  logic                               ldRegEn,
  input  logic [7:0]                         ldAddr,
  input  logic [15:0]                        ldData,
  input  logic [3:0]                         peekReg,
  output logic [15:0]                        peekData,
  output logic [7:0]                         pcOut,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    fifoLevel,
  output logic                               done
);
  pipe_strobe_t       strb;
  logic [INSTR_W-1:0] headInstr;
  logic               headZero;

  fifo_pipe_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .fifoLevel(fifoLevel),
    .headOp(headInstr[15:14]), .headZero(headZero), .strb(strb), .done(done)
  );

  fifo_pipe_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldImemEn(ldImemEn), .ldRegEn(ldRegEn),
    .ldAddr(ldAddr), .ldData(ldData), .peekReg(peekReg), .peekData(peekData),
    .pcOut(pcOut), .fifoLevel(fifoLevel), .headInstr(headInstr), .headZero(headZero)
  );
endmodule

// File: rtl/fifo_pipe_checker.sv
module fifo_pipe_checker
  import fifo_pipe_pkg::*;
#(
  parameter int FIFO_DEPTH = 2,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input pipe_strobe_t     strb,
  input logic [7:0]       branchTarget,
  input logic [7:0]       pcOut,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             done
);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(FIFO_DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LVL_W'(FIFO_DEPTH) && !strb.branchTaken) |=> $stable(pcOut));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> ($stable(pcOut) && $stable(fifoLevel)));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fetch && !strb.branchTaken) |=> (pcOut == $past(pcOut) + 8'd1));

  p_taken_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.branchTaken |=> (fifoLevel == '0));

  p_taken_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.branchTaken |=> (pcOut == $past(branchTarget)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_no_exec_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strb.dequeue);
endmodule

bind fifo_pipe fifo_pipe_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .run(run), .strb(strb), .branchTarget(headInstr[7:0]),
  .pcOut(pcOut), .fifoLevel(fifoLevel), .done(done)
);

// File: tb/fifo_pipe_bench.sv
module fifo_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2;
  localparam logic [15:0] HALT = 16'h8000;

  logic clk = 1'b0;
  logic rstN = 1'b0, run = 1'b0, ldImemEn = 1'b0, ldRegEn = 1'b0;
  logic [7:0] ldAddr = '0;
  logic [15:0] ldData = '0;
  logic [3:0] peekReg = '0;
  logic [15:0] peekData;
  logic [7:0] pcOut;
  logic [1:0] fifoLevel;
  logic done;

  int total = 0;
  int bad = 0;
  logic [15:0] prog [64];
  logic [15:0] initReg [16];
  logic [15:0] mReg [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_pipe #(.FIFO_DEPTH(DEPTH)) u_fifo_pipe (
    .clk(clk), .rstN(rstN), .run(run), .ldImemEn(ldImemEn), .ldRegEn(ldRegEn),
    .ldAddr(ldAddr), .ldData(ldData), .peekReg(peekReg), .peekData(peekData),
    .pcOut(pcOut), .fifoLevel(fifoLevel), .done(done)
  );

  function automatic logic [15:0] encAdd(input int d, input int a, input int b);
    return {2'b00, 4'(d), 4'(a), 4'(b), 2'b00};
  endfunction

  function automatic logic [15:0] encBz(input int r, input int t);
    return {2'b01, 4'(r), 2'b00, 8'(t)};
  endfunction

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    run = 1'b0; rstN = 1'b0;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic loadAll();
    for (int a = 0; a < 64; a++) begin
      ldImemEn = 1'b1; ldAddr = 8'(a); ldData = prog[a];
      step(1);
    end
    ldImemEn = 1'b0;
    for (int r = 0; r < 16; r++) begin
      ldRegEn = 1'b1; ldAddr = 8'(r); ldData = initReg[r];
      step(1);
    end
    ldRegEn = 1'b0;
  endtask

  task automatic runUntilDone(input int limit, output int cycles);
    run = 1'b1;
    cycles = 0;
    while (!done && cycles < limit) begin
      step(1);
      cycles++;
    end
    run = 1'b0;
  endtask

  task automatic modelRun();
    int pc = 0;
    for (int r = 0; r < 16; r++) mReg[r] = initReg[r];
    for (int s = 0; s < 500; s++) begin
      logic [15:0] w = prog[pc & 63];
      if (w[15]) break;
      if (w[14] == 1'b0) begin
        mReg[w[13:10]] = mReg[w[9:6]] + mReg[w[5:2]];
        pc++;
      end else if (mReg[w[13:10]] == 16'd0) pc = int'(w[7:0]);
      else pc++;
    end
  endtask

  task automatic checkRegs(input string tag);
    for (int r = 0; r < 16; r++) begin
      peekReg = 4'(r);
      #1;
      chkEq($sformatf("%s reg%0d", tag, r), 32'(peekData), 32'(mReg[r]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();
    chkEq("R1 pc after reset", 32'(pcOut), 0);
    chkEq("R1 level after reset", 32'(fifoLevel), 0);
    chkEq("R1 done after reset", 32'(done), 0);

    // R9 load port and R2 idle: all-halt program
    for (int a = 0; a < 64; a++) prog[a] = HALT;
    for (int r = 0; r < 16; r++) initReg[r] = 16'(r * 7 + 1);
    loadAll();
    peekReg = 4'd5; #1;
    chkEq("R9 peek loaded register", 32'(peekData), 36);
    chkEq("R2 pc idle while run low", 32'(pcOut), 0);
    chkEq("R2 level idle while run low", 32'(fifoLevel), 0);

    // R3 full guard and R8 halt behaviour
    run = 1'b1;
    step(1);
    chkEq("R2 pc after first fetch", 32'(pcOut), 1);
    chkEq("R2 level after first fetch", 32'(fifoLevel), 1);
    step(1);
    chkEq("R8 done after halt at head", 32'(done), 1);
    step(3);
    chkEq("R3 level capped at depth", 32'(fifoLevel), DEPTH);
    chkEq("R3 pc holds while full", 32'(pcOut), DEPTH);
    chkEq("R8 done sticky", 32'(done), 1);
    run = 1'b0;

    // R7 / R4 straight-line adds
    doReset();
    for (int a = 0; a < 64; a++) prog[a] = HALT;
    for (int r = 0; r < 16; r++) initReg[r] = 16'd0;
    initReg[1] = 16'd3; initReg[2] = 16'd5;
    prog[0] = encAdd(3, 1, 2);
    prog[1] = encAdd(4, 3, 1);
    prog[2] = encAdd(5, 4, 4);
    prog[3] = encAdd(1, 5, 2);
    loadAll();
    runUntilDone(100, cyc);
    chkEq("R7 back-to-back completion cycles", 32'(cyc), 6);
    peekReg = 4'd1; #1;
    chkEq("R4 chained add result", 32'(peekData), 27);
    modelRun();
    checkRegs("R4 straight-line");

    // R6 taken branch with same-cycle fetch
    doReset();
    for (int a = 0; a < 64; a++) prog[a] = HALT;
    for (int r = 0; r < 16; r++) initReg[r] = 16'd1;
    initReg[0] = 16'd0; initReg[1] = 16'd7;
    prog[0] = encBz(0, 5);
    for (int a = 1; a < 5; a++) prog[a] = encAdd(1, 1, 1);
    loadAll();
    run = 1'b1;
    step(1);
    chkEq("R6 pc before branch", 32'(pcOut), 1);
    step(1);
    chkEq("R6 pc redirected to target", 32'(pcOut), 5);
    chkEq("R6 queue flushed", 32'(fifoLevel), 0);
    step(2);
    chkEq("R6 halt reached after redirect", 32'(done), 1);
    run = 1'b0;
    peekReg = 4'd1; #1;
    chkEq("R6 wrong path not executed", 32'(peekData), 7);

    // R5 not-taken branch
    doReset();
    for (int a = 0; a < 64; a++) prog[a] = HALT;
    for (int r = 0; r < 16; r++) initReg[r] = 16'(r + 1);
    initReg[2] = 16'd9;
    prog[0] = encBz(2, 4);
    prog[1] = encAdd(3, 2, 2);
    loadAll();
    runUntilDone(100, cyc);
    chkEq("R5 not-taken completion cycles", 32'(cyc), 4);
    peekReg = 4'd3; #1;
    chkEq("R5 fall-through executed", 32'(peekData), 18);
    modelRun();
    checkRegs("R5 not-taken");

    // R8 opcode 11 also stops
    doReset();
    for (int a = 0; a < 64; a++) prog[a] = 16'hC000;
    loadAll();
    runUntilDone(50, cyc);
    chkEq("R8 opcode 11 stops", 32'(cyc), 2);

    // R10 random programs vs sequential model
    for (int t = 0; t < 30; t++) begin
      int len = 8 + int'($urandom % 10);
      doReset();
      for (int a = 0; a < 64; a++) prog[a] = HALT;
      for (int i = 0; i < len; i++) begin
        if (($urandom % 10) < 3)
          prog[i] = encBz(int'($urandom % 16), i + 1 + int'($urandom % (len - i)));
        else
          prog[i] = encAdd(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
      end
      for (int r = 0; r < 16; r++)
        initReg[r] = (($urandom % 3) == 0) ? 16'd0 : 16'($urandom);
      loadAll();
      runUntilDone(300, cyc);
      chkEq("R10 random program halted", 32'(done), 1);
      modelRun();
      checkRegs("R10 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule